// File: doc/BRIEF.md
# SMBus Block-Mode Register Target

This block is the serial front end of a small configuration register bank. It samples the SCL and SDA wires with the system clock and cleans them up. It detects START, repeated START and STOP conditions. It pulls SDA low through an open-drain enable when it acknowledges a byte or sends a 0 bit. Toward the bank it presents a byte address, write data, a write strobe, and a read strobe with combinational read data.

The native protocol is block mode.

- **Writes.** A write carries a command byte, then a byte count, then that many data bytes. The data bytes go to consecutive indices.
- **Reads.** A read first sets the index with a short write. It then issues a repeated START and the read address. The target answers with the count held in a fixed count register, then with data from the index onward. It keeps sending while the host acknowledges.
- **Byte mode.** Setting the top bit of the command byte selects plain byte mode. Byte mode drops the count in both directions.

Top module: `smb_blk_target`

## Requirements
- R1: SCL and SDA each pass through a synchronizer and a filter that changes its output only after 3 equal samples. A pulse of 2 system cycles or less on either line has no effect on any transfer.
- R2: The target acknowledges address byte D2h (write) and D3h (read), 8-bit form with R/W in bit 0. Any other address is not acknowledged, and every following byte is ignored and not acknowledged until the next START.
- R3: In block mode, a write carries command byte C, count X, then X data bytes. Index bits [6:0] of C select the start index N, and data byte i goes to index N+i. The target acknowledges the address, command, count and each of the X data bytes.
- R4: In a block-mode write, data bytes beyond the count X are not acknowledged and not written. This includes every data byte when X is 0.
- R5: A block read consists of address D2h, command C, repeated START and address D3h. The target returns the value of register CNT_IDX (default 8) first, then the bytes at N, N+1, and so on. The index set by the write survives the repeated START.
- R6: During a read, the target sends a further byte only while the host acknowledges. After a host NACK it leaves SDA released.
- R7: When command bit 7 is 1, a write is in byte mode. No count is expected, and every data byte, starting with the first byte after the command, is written to consecutive indices and acknowledged.
- R8: When the last command had bit 7 set, a read returns data bytes from the index directly, with no count byte in front.
- R9: A START or STOP that arrives before the 8th bit of a byte aborts the transfer. The partial byte is not written.
- R10: SDA is only ever pulled low, never driven high. The enable changes only while the filtered SCL is low. The target releases SDA once a transfer ends.
- R11: After reset, SDA is released and neither strobe is active.
- R12: A write strobe and a read strobe last one cycle each and never occur together. A write occurs while SCL is high, and a read occurs while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock wire |
| sda_i | input | 1 | Serial data wire as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | AW | Register index for read or write |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_re_o | output | 1 | Single-cycle read strobe; data captured this cycle |
| reg_rdata_i | input | 8 | Combinational read data for reg_addr_o |

## Verification
The bound checker checks the register-port and drive rules of R10 and R12 on every cycle:
- strobe width,
- mutual exclusion of the two strobes,
- the SCL level at each strobe,
- SDA enable changes only while SCL is low.

Only the bench scenarios can show the protocol behaviour: which addresses are acknowledged, count handling, index placement, byte mode, the count-first read, aborts and glitch rejection. The bench drives whole bus transactions and compares the bank contents and the bytes it reads back against its own model.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_WDAT, PH_RCNT, PH_RDAT, PH_SKIP
  } phase_e;
endpackage

// File: rtl/smb_line_filt.sv
module smb_line_filt #(
  parameter int SYNC = 2,
  parameter int TAPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC-1:0] sync_q;
  logic [TAPS-1:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], line_i};
      tap_q  <= {tap_q[TAPS-2:0], sync_q[SYNC-1]};
      if (&tap_q)       line_o <= 1'b1;
      else if (~|tap_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_bus_evt.sv
module smb_bus_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_pkg::*;
#(
  parameter int          AW      = 8,
  parameter logic [7:0]  WR_ADDR = 8'hD2,
  parameter logic [7:0]  RD_ADDR = 8'hD3,
  parameter logic [AW-1:0] CNT_IDX = AW'(8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  output logic          we_o,
  output logic          re_o,
  input  logic [7:0]    rdata_i
);
  phase_e        ph_q;
  logic [3:0]    bit_q;
  logic [6:0]    rx_q, tx_q;
  logic [AW-1:0] idx_q;
  logic [7:0]    left_q;
  logic          bmode_q, ack_pend_q, ack_drv_q, tx_low_q, tx_byte_q;

  logic [7:0] rx_byte;
  logic       active, tx_ph, last_bit, room, load;

  assign rx_byte  = {rx_q, sda_i};
  assign active   = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);
  assign tx_ph    = (ph_q == PH_RCNT) || (ph_q == PH_RDAT);
  assign last_bit = rise_i && active && !tx_byte_q && (bit_q == 4'd7);
  assign room     = bmode_q || (left_q != 8'd0);
  assign load     = fall_i && tx_ph && (bit_q == 4'd9);

  assign we_o     = last_bit && (ph_q == PH_WDAT) && room;
  assign wdata_o  = rx_byte;
  assign re_o     = load;
  assign addr_o   = (ph_q == PH_RCNT) ? CNT_IDX : idx_q;
  assign sda_oe_o = ack_drv_q | tx_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;  bit_q <= '0;  rx_q <= '0;  tx_q <= '0;
      idx_q <= '0;  left_q <= '0;  bmode_q <= 1'b0;  ack_pend_q <= 1'b0;
      ack_drv_q <= 1'b0;  tx_low_q <= 1'b0;  tx_byte_q <= 1'b0;
    end else if (start_i || stop_i) begin
      // idx and mode survive a repeated START
      ph_q <= start_i ? PH_ADDR : PH_IDLE;
      bit_q <= '0;  ack_pend_q <= 1'b0;  ack_drv_q <= 1'b0;
      tx_low_q <= 1'b0;  tx_byte_q <= 1'b0;
    end else begin
      if (rise_i && active) begin
        if (bit_q < 4'd8) begin
          bit_q <= bit_q + 4'd1;
          rx_q  <= rx_byte[6:0];
        end else if (bit_q == 4'd8) begin
          bit_q <= 4'd9;
          if (tx_byte_q && sda_i) ph_q <= PH_SKIP;  // host NACK
        end
        if (last_bit) begin
          ack_pend_q <= 1'b1;
          unique case (ph_q)
            PH_ADDR: begin
              if (rx_byte == WR_ADDR)      ph_q <= PH_CMD;
              else if (rx_byte == RD_ADDR) ph_q <= bmode_q ? PH_RDAT : PH_RCNT;
              else begin ph_q <= PH_SKIP; ack_pend_q <= 1'b0; end
            end
            PH_CMD: begin
              idx_q   <= AW'(rx_byte[6:0]);
              bmode_q <= rx_byte[7];
              ph_q    <= rx_byte[7] ? PH_WDAT : PH_CNT;
            end
            PH_CNT: begin
              left_q <= rx_byte;
              ph_q   <= PH_WDAT;
            end
            PH_WDAT: begin
              if (room) begin
                idx_q <= idx_q + AW'(1);
                if (!bmode_q) left_q <= left_q - 8'd1;
              end else begin
                ph_q <= PH_SKIP;
                ack_pend_q <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      if (fall_i && active) begin
        if (bit_q == 4'd8) begin
          tx_low_q  <= 1'b0;
          ack_drv_q <= ack_pend_q;
        end else if (bit_q == 4'd9) begin
          bit_q      <= '0;
          ack_drv_q  <= 1'b0;
          ack_pend_q <= 1'b0;
          tx_byte_q  <= tx_ph;
          if (tx_ph) begin
            tx_q     <= rdata_i[6:0];
            tx_low_q <= ~rdata_i[7];
            if (ph_q == PH_RCNT) ph_q <= PH_RDAT;
            else                 idx_q <= idx_q + AW'(1);
          end
        end else if (tx_byte_q && bit_q != 4'd0) begin
          tx_low_q <= ~tx_q[6];
          tx_q     <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target #(
  parameter int            AW          = 8,
  parameter logic [7:0]    WR_ADDR     = 8'hD2,
  parameter logic [7:0]    RD_ADDR     = 8'hD3,
  parameter logic [AW-1:0] CNT_IDX     = AW'(8),
  parameter int            SYNC_STAGES = 2,
  parameter int            FILT_TAPS   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [7:0]    reg_rdata_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic start, stop, rise, fall;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    smb_line_filt #(.SYNC(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk_i, .rst_ni, .line_i(raw[g]), .line_o(filt[g])
    );
  end

  smb_bus_evt u_evt (
    .clk_i, .rst_ni, .scl_i(filt[1]), .sda_i(filt[0]),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  smb_xfer_fsm #(.AW(AW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .CNT_IDX(CNT_IDX)) u_fsm (
    .clk_i, .rst_ni, .sda_i(filt[0]),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .sda_oe_o, .addr_o(reg_addr_o), .wdata_o(reg_wdata_o),
    .we_o(reg_we_o), .re_o(reg_re_o), .rdata_i(reg_rdata_i)
  );
endmodule

// File: rtl/smb_blk_target_chk.sv
module smb_blk_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f_i,
  input logic sda_oe_i,
  input logic we_i,
  input logic re_i
);
  // R10
  oe_change_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !$past(scl_f_i));
  // R12
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i);
  // R12
  re_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> !re_i);
  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
  // R12
  we_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> scl_f_i);
  // R12
  re_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |-> !scl_f_i);
endmodule

bind smb_blk_target smb_blk_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_f_i(filt[1]),
  .sda_oe_i(sda_oe_o), .we_i(reg_we_o), .re_i(reg_re_o)
);

// File: tb/smb_blk_target_test.sv
module smb_blk_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl = 1'b1, hlow = 1'b0, glitch = 1'b0;
  logic sda_oe, we, re;
  logic [7:0] addr, wdata, rdata;
  logic sda_line;
  assign sda_line = ~(hlow | sda_oe | glitch);

  logic [7:0] mem [256];
  logic [7:0] exp_m [256];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (we) mem[addr] <= wdata;
  end
  assign rdata = mem[addr];

  smb_blk_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    hlow = 1'b0; scl = 1'b1; tq();
    hlow = 1'b1; tq();
    scl = 1'b0; tq();
  endtask

  task automatic bus_rstart();
    hlow = 1'b0; tq();
    scl = 1'b1; tq();
    hlow = 1'b1; tq();
    scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    hlow = 1'b1; tq();
    scl = 1'b1; tq();
    hlow = 1'b0; tq();
  endtask

  task automatic sbit(input bit b);
    hlow = ~b; tq();
    scl = 1'b1; tq(); tq();
    scl = 1'b0; tq();
  endtask

  // sends a 1 with a 2-cycle low pulse on SDA while SCL is high
  task automatic sbit_glitch();
    hlow = 1'b0; tq();
    scl = 1'b1;
    repeat (4) @(negedge clk);
    glitch = 1'b1;
    repeat (2) @(negedge clk);
    glitch = 1'b0;
    repeat (2*Q-6) @(negedge clk);
    scl = 1'b0; tq();
  endtask

  task automatic rbit(output bit b);
    hlow = 1'b0; tq();
    scl = 1'b1; tq();
    b = sda_line; tq();
    scl = 1'b0; tq();
  endtask

  task automatic sbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit hack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    sbit(~hack);
  endtask

  task automatic cmp_range(input int n, input int x, input string tag);
    int bad = 0, first_a = 0, first_e = 0;
    for (int i = 0; i < x; i++) begin
      if (mem[(n+i)%256] !== exp_m[(n+i)%256]) begin
        if (bad == 0) begin first_a = int'(mem[(n+i)%256]); first_e = int'(exp_m[(n+i)%256]); end
        bad++;
      end
    end
    chk(bad == 0, tag, first_a, first_e);
  endtask

  task automatic blk_write(input int n, input int x);
    bit a, all_ack;
    logic [7:0] d;
    all_ack = 1'b1;
    bus_start();
    sbyte(8'hD2, a); all_ack &= a;
    sbyte(8'(n), a); all_ack &= a;
    sbyte(8'(x), a); all_ack &= a;
    for (int i = 0; i < x; i++) begin
      d = 8'($urandom);
      sbyte(d, a); all_ack &= a;
      exp_m[n+i] = d;
    end
    bus_stop();
    chk(all_ack, "R3 every write byte acked", int'(all_ack), 1);
    cmp_range(n, x, "R3 block write contents");
  endtask

  task automatic blk_read(input int n, input int k);
    bit a;
    logic [7:0] d;
    bus_start();
    sbyte(8'hD2, a);
    sbyte(8'(n), a);
    bus_rstart();
    sbyte(8'hD3, a);
    chk(a, "R2 read address acked", int'(a), 1);
    rbyte(d, 1'b1);
    chk(d == exp_m[8], "R5 count byte first", int'(d), int'(exp_m[8]));
    for (int i = 0; i < k; i++) begin
      rbyte(d, i < k-1);
      chk(d == exp_m[n+i], "R5 read data from index", int'(d), int'(exp_m[n+i]));
    end
    bus_stop();
    repeat (8) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 SDA released after host NACK", int'(sda_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a, a1, a2;
    logic [7:0] d, d0, d1;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) exp_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 SDA released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && we == 1'b0 && re == 1'b0, "R11 idle after reset",
        int'({sda_oe, we, re}), 0);

    // R7: byte-mode write sets the count register (index 8) to 3
    bus_start();
    sbyte(8'hD2, a); sbyte(8'h88, a1); sbyte(8'h03, a2);
    bus_stop();
    exp_m[8] = 8'h03;
    chk(a && a1 && a2, "R7 byte mode acks", int'({a, a1, a2}), 7);
    cmp_range(8, 1, "R7 byte-mode write to index 8");

    // R7: multi-byte byte-mode write
    bus_start();
    sbyte(8'hD2, a); sbyte(8'hF0, a);
    for (int i = 0; i < 3; i++) begin
      d = 8'($urandom); sbyte(d, a1); exp_m[112+i] = d;
      chk(a1, "R7 byte-mode data acked", int'(a1), 1);
    end
    bus_stop();
    cmp_range(112, 3, "R7 consecutive byte-mode indices");

    // R3 / R5: random block writes and block reads
    for (int t = 0; t < 6; t++) begin
      int n, x;
      n = 16 + int'($urandom_range(0, 84));
      x = 1 + int'($urandom_range(0, 5));
      blk_write(n, x);
      blk_read(n, 3);
      chk(sda_oe == 1'b0, "R10 SDA released after transfer", int'(sda_oe), 0);
    end

    // R8: byte-mode read, no count byte
    bus_start();
    sbyte(8'hD2, a); sbyte(8'h80 | 8'd112, a);
    bus_rstart();
    sbyte(8'hD3, a);
    rbyte(d0, 1'b1); rbyte(d1, 1'b0);
    bus_stop();
    chk(d0 == exp_m[112], "R8 first byte is data", int'(d0), int'(exp_m[112]));
    chk(d1 == exp_m[113], "R8 second byte", int'(d1), int'(exp_m[113]));

    // R2: foreign address ignored until next START
    bus_start();
    sbyte(8'hA0, a); sbyte(8'h90, a1); sbyte(8'h55, a2);
    bus_stop();
    chk(!a, "R2 foreign address NACK", int'(a), 0);
    chk(!a1 && !a2, "R2 later bytes NACK", int'({a1, a2}), 0);
    cmp_range(16, 1, "R2 no write after foreign address");

    // R4: byte beyond count
    bus_start();
    sbyte(8'hD2, a); sbyte(8'd50, a); sbyte(8'd1, a);
    d = 8'h3C; sbyte(d, a1); exp_m[50] = d;
    sbyte(8'hC3, a2);
    bus_stop();
    chk(a1, "R4 counted byte acked", int'(a1), 1);
    chk(!a2, "R4 excess byte NACK", int'(a2), 0);
    cmp_range(50, 2, "R4 excess byte not written");

    // R4: count zero
    bus_start();
    sbyte(8'hD2, a); sbyte(8'd70, a); sbyte(8'd0, a1); sbyte(8'hEE, a2);
    bus_stop();
    chk(a1 && !a2, "R4 zero count", int'({a1, a2}), 2);
    cmp_range(70, 1, "R4 zero count no write");

    // R9: STOP mid-byte
    bus_start();
    sbyte(8'hD2, a); sbyte(8'd60, a); sbyte(8'd2, a);
    d = 8'hA5; sbyte(d, a); exp_m[60] = d;
    for (int i = 0; i < 4; i++) sbit(1'b0);
    bus_stop();
    cmp_range(60, 2, "R9 partial byte not written");
    repeat (8) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 idle after abort", int'(sda_oe), 0);

    // R1: short glitches on SDA while SCL high
    bus_start();
    sbyte(8'hD2, a); sbyte(8'd30, a); sbyte(8'd2, a);
    d = 8'h5A; sbyte(d, a1); exp_m[30] = d;
    sbit_glitch();
    for (int i = 6; i >= 0; i--) sbit(1'b1);
    rbit(a2);
    exp_m[31] = 8'hFF;
    bus_stop();
    chk(a1 && !a2, "R1 transfer survives glitch", int'({a1, a2}), 2);
    cmp_range(30, 2, "R1 glitch-free write contents");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule